// File: doc/BRIEF.md
# Serial Latch-Addressed Configuration Receiver

This block is the device-side end of a write-only three-wire configuration port for a frequency synthesizer. An external controller drives a serial clock, a data line and a load strobe. Every rising edge of the serial clock shifts one data bit into a 24-bit shift register. A rising edge on the load strobe copies the assembled word into one of four control latches. The two lowest bits of the word select the latch.

All four pins are asynchronous to the core clock. Each one passes through a synchronizer, and edges are detected in the core domain. The block presents the four latch words and an output-active flag to the rest of the chip. After reset the flag stays low until each of the four latches has been written at least once. A low chip-enable input holds the flag low without disturbing the stored words.

Top module: `synth_cfg_rx`

## Requirements
- R1: After reset all four latch outputs are zero and `outActive` is 0.
- R2: Data is shifted most significant bit first. The bit sampled on the last serial clock rise before the load strobe rises becomes bit 0 of the stored word, and the whole 24-bit word is stored unaltered, including its address bits.
- R3: Bits [1:0] of the word choose the destination: 00 goes to `rCounter`, 01 to `nCounter`, 10 to `funcWord` and 11 to `initWord`. The other three latches keep their contents.
- R4: `outActive` rises only after every one of the four latches has been written since reset. Three distinct writes are not enough.
- R5: A transfer happens only on a rising edge of the load strobe. Holding it high while more bits are shifted changes no latch. The next transfer needs a fall followed by a new rise.
- R6: While `chipEn` is low, `outActive` is 0 and the latch contents are kept. When `chipEn` returns high, `outActive` returns to 1 without any rewrite.
- R7: If more than 24 bits are shifted before a load, only the last 24 are kept.
- R8: With two synchronizer stages, the selected latch still holds its old value two core cycles after the load strobe rises at the pin. It holds the new word after the third core cycle.
- R9: Writing a latch that already holds a word replaces that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, sampled on serClk rise |
| latchEn | input | 1 | Load strobe, transfer on rising edge |
| chipEn | input | 1 | Chip enable, low forces power-down |
| rCounter | output | 24 | Latch selected by address 00 |
| nCounter | output | 24 | Latch selected by address 01 |
| funcWord | output | 24 | Latch selected by address 10 |
| initWord | output | 24 | Latch selected by address 11 |
| outActive | output | 1 | High once all latches are written and chip enabled |

## Verification
Each pin change takes two core cycles to cross the synchronizer. The resulting strobe acts on the third rising edge, so a latch changes three cycles after the load pin rises, and `outActive` follows one cycle later. The bench changes inputs and samples outputs on falling clock edges. It samples a latch at the second falling edge after the load rise, where the old value must still be present, and again at the third, where the new word is due. Checks on `outActive` and on chip-enable wait several cycles past the fourth edge.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int CFG_WORD_W    = 24;
  localparam int CFG_NUM_LATCH = 4;
  localparam int CFG_ADDR_W    = $clog2(CFG_NUM_LATCH);

  typedef enum logic [CFG_ADDR_W-1:0] {
    SEL_RCNT = 2'd0,
    SEL_NCNT = 2'd1,
    SEL_FUNC = 2'd2,
    SEL_INIT = 2'd3
  } latchSel_t;

  // strobes from control to datapath, one core cycle wide
  typedef struct packed {
    logic shift;   // serial clock rose
    logic bitIn;   // synchronised data bit
    logic load;    // load strobe rose
    logic chipOn;  // synchronised chip enable level
  } cfgStrobe_t;

endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serClk,
  input  logic       serData,
  input  logic       latchEn,
  input  logic       chipEn,
  output cfgStrobe_t stb
);

  localparam int PIN_CNT = 4;
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LE  = 2;
  localparam int IDX_CE  = 3;

  logic [PIN_CNT-1:0] pinRaw;
  logic [PIN_CNT-1:0] pinSync;
  logic               clkPrev;
  logic               lePrev;

  assign pinRaw = {chipEn, latchEn, serData, serClk};

  synth_cfg_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (PIN_CNT)
  ) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .asyncIn(pinRaw),
    .syncOut(pinSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev <= 1'b0;
      lePrev  <= 1'b0;
    end else begin
      clkPrev <= pinSync[IDX_CLK];
      lePrev  <= pinSync[IDX_LE];
    end
  end

  always_comb begin
    stb.shift  = pinSync[IDX_CLK] & ~clkPrev;
    stb.bitIn  = pinSync[IDX_DAT];
    stb.load   = pinSync[IDX_LE] & ~lePrev;
    stb.chipOn = pinSync[IDX_CE];
  end

endmodule

// File: rtl/synth_cfg_dpath.sv
module synth_cfg_dpath
  import synth_cfg_pkg::*;
#(
  parameter int WORD_W    = CFG_WORD_W,
  parameter int NUM_LATCH = CFG_NUM_LATCH
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  cfgStrobe_t                         stb,
  output logic [NUM_LATCH-1:0][WORD_W-1:0]   latchQ,
  output logic [WORD_W-1:0]                  wordQ,
  output logic [NUM_LATCH-1:0]               writtenMask,
  output logic                               activeQ
);

  localparam int ADDR_W = $clog2(NUM_LATCH);

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] addrField;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shiftReg <= '0;
    else if (stb.shift) shiftReg <= {shiftReg[WORD_W-2:0], stb.bitIn};
  end

  assign addrField = shiftReg[ADDR_W-1:0];
  assign wordQ     = shiftReg;

  for (genvar g = 0; g < NUM_LATCH; g++) begin : gLatch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latchQ[g]      <= '0;
        writtenMask[g] <= 1'b0;
      end else if (stb.load && (addrField == ADDR_W'(g))) begin
        latchQ[g]      <= shiftReg;
        writtenMask[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) activeQ <= 1'b0;
    else        activeQ <= (&writtenMask) & stb.chipOn;
  end

endmodule

// File: rtl/synth_cfg_rx.sv
module synth_cfg_rx
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  serClk,
  input  logic                  serData,
  input  logic                  latchEn,
  input  logic                  chipEn,
  output logic [CFG_WORD_W-1:0] rCounter,
  output logic [CFG_WORD_W-1:0] nCounter,
  output logic [CFG_WORD_W-1:0] funcWord,
  output logic [CFG_WORD_W-1:0] initWord,
  output logic                  outActive
);

  cfgStrobe_t                                 ctlStb;
  logic [CFG_NUM_LATCH-1:0][CFG_WORD_W-1:0]   latchQ;
  logic [CFG_WORD_W-1:0]                      wordQ;
  logic [CFG_NUM_LATCH-1:0]                   writtenMask;

  synth_cfg_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .serClk (serClk),
    .serData(serData),
    .latchEn(latchEn),
    .chipEn (chipEn),
    .stb    (ctlStb)
  );

  synth_cfg_dpath #(
    .WORD_W   (CFG_WORD_W),
    .NUM_LATCH(CFG_NUM_LATCH)
  ) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (ctlStb),
    .latchQ     (latchQ),
    .wordQ      (wordQ),
    .writtenMask(writtenMask),
    .activeQ    (outActive)
  );

  assign rCounter = latchQ[SEL_RCNT];
  assign nCounter = latchQ[SEL_NCNT];
  assign funcWord = latchQ[SEL_FUNC];
  assign initWord = latchQ[SEL_INIT];

endmodule

// File: rtl/synth_cfg_rx_chk.sv
module synth_cfg_rx_chk
  import synth_cfg_pkg::*;
(
  input logic                                clk,
  input logic                                rst_n,
  input cfgStrobe_t                          stb,
  input logic [CFG_NUM_LATCH-1:0][CFG_WORD_W-1:0] latchQ,
  input logic [CFG_WORD_W-1:0]               wordQ,
  input logic [CFG_NUM_LATCH-1:0]            writtenMask,
  input logic                                outActive
);

  for (genvar g = 0; g < CFG_NUM_LATCH; g++) begin : gRoute
    AST_LOAD_ROUTES: assert property (@(posedge clk) disable iff (!rst_n)
      stb.load && (wordQ[CFG_ADDR_W-1:0] == CFG_ADDR_W'(g)) |=> latchQ[g] == $past(wordQ)); // R3
    AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      writtenMask[g] |=> writtenMask[g]); // R4
  end

  AST_NO_LOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.load |=> $stable(latchQ)); // R5

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> !stb.load); // R5

  AST_ACTIVE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    outActive |-> &writtenMask); // R4

  AST_CE_LOW_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.chipOn |=> !outActive); // R6

endmodule

bind synth_cfg_rx synth_cfg_rx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .stb        (ctlStb),
  .latchQ     (latchQ),
  .wordQ      (wordQ),
  .writtenMask(writtenMask),
  .outActive  (outActive)
);

// File: tb/synth_cfg_rx_tb_top.sv
`timescale 1ns/1ps
module synth_cfg_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        latchEn = 1'b0;
  logic        chipEn = 1'b1;
  logic [23:0] rCounter, nCounter, funcWord, initWord;
  logic        outActive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  synth_cfg_rx dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .serClk   (serClk),
    .serData  (serData),
    .latchEn  (latchEn),
    .chipEn   (chipEn),
    .rCounter (rCounter),
    .nCounter (nCounter),
    .funcWord (funcWord),
    .initWord (initWord),
    .outActive(outActive)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // shift the low n bits of v, most significant first
  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      serData = v[i];
      waitNeg(3);
      serClk = 1'b1;
      waitNeg(4);
      serClk = 1'b0;
    end
    waitNeg(4);
  endtask

  task automatic pulseLoad();
    @(negedge clk);
    latchEn = 1'b1;
    waitNeg(6);
    latchEn = 1'b0;
    waitNeg(4);
  endtask

  task automatic writeWord(input logic [23:0] w);
    sendBits({8'h00, w}, 24);
    pulseLoad();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    waitNeg(3);
    chk("R1 rCounter", rCounter, 24'h0);
    chk("R1 nCounter", nCounter, 24'h0);
    chk("R1 funcWord", funcWord, 24'h0);
    chk("R1 initWord", initWord, 24'h0);
    chk("R1 outActive", {23'h0, outActive}, 24'h0);
    rst_n = 1'b1;
    waitNeg(3);
  endtask

  task automatic t_routing();
    writeWord(24'h5A3C10);
    chk("R2 R3 rCounter word", rCounter, 24'h5A3C10);
    chk("R3 nCounter untouched", nCounter, 24'h0);
    chk("R3 funcWord untouched", funcWord, 24'h0);
    writeWord(24'h123455);
    chk("R3 nCounter word", nCounter, 24'h123455);
    writeWord(24'hC0FFEE);
    chk("R3 funcWord word", funcWord, 24'hC0FFEE);
    chk("R3 rCounter kept", rCounter, 24'h5A3C10);
    waitNeg(6);
    chk("R4 inactive after three", {23'h0, outActive}, 24'h0);
    writeWord(24'h800003);
    chk("R3 initWord word", initWord, 24'h800003);
    waitNeg(4);
    chk("R4 active after four", {23'h0, outActive}, 24'h1);
  endtask

  task automatic t_timing();
    sendBits({8'h00, 24'h0BEEF4}, 24);
    @(negedge clk);
    latchEn = 1'b1;
    waitNeg(2);
    chk("R8 old value two cycles after load", rCounter, 24'h5A3C10);
    waitNeg(1);
    chk("R8 R9 new value third cycle", rCounter, 24'h0BEEF4);
    waitNeg(4);
    latchEn = 1'b0;
    waitNeg(4);
  endtask

  task automatic t_hold();
    @(negedge clk);
    latchEn = 1'b1;
    waitNeg(6);
    sendBits({8'h00, 24'h00AB01}, 24);
    waitNeg(6);
    chk("R5 no transfer while held", nCounter, 24'h123455);
    latchEn = 1'b0;
    waitNeg(6);
    pulseLoad();
    chk("R5 transfer after new rise", nCounter, 24'h00AB01);
  endtask

  task automatic t_overflow();
    sendBits({2'b00, 6'h3F, 24'h0F0F02}, 30);
    pulseLoad();
    chk("R7 last 24 bits kept", funcWord, 24'h0F0F02);
  endtask

  task automatic t_chipEnable();
    @(negedge clk);
    chipEn = 1'b0;
    waitNeg(8);
    chk("R6 inactive with chip disabled", {23'h0, outActive}, 24'h0);
    chk("R6 rCounter retained", rCounter, 24'h0BEEF4);
    chk("R6 initWord retained", initWord, 24'h800003);
    chipEn = 1'b1;
    waitNeg(8);
    chk("R6 active restored", {23'h0, outActive}, 24'h1);
  endtask

  initial begin
    t_reset();
    t_routing();
    t_timing();
    t_hold();
    t_overflow();
    t_chipEnable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule